// File: doc/BRIEF.md
# Dual-Width Fetch and Exception-Entry Sequencer

This block owns the program counter of a core that runs either 32-bit or 16-bit instructions. It issues one fetch at a time, holds the returned instruction together with its address, and produces the program-counter value that software sees. For 32-bit instructions it also decides whether the held instruction may execute by testing its 4-bit condition field against the N, Z, C and V flags of the status word. For 16-bit instructions that decision is always "execute".

At each instruction boundary the sequencer can take an interrupt or a prefetch abort. On entry it captures the old status word and a return address. It builds the new status word and asks the register file to switch mode, all in one cycle. It then fetches from the selected vector in 32-bit state. A strap input selects a high or low vector base. A halt request parks the sequencer until an exception arrives. Each fetch carries a wait-cycle hint, which is looked up from one of two per-width tables indexed by the address nibble at bits 27:24.

Top module: `fetch_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, the block requests a 32-bit fetch at RESET_ADDR with no instruction held and no mode switch.
- R2: A fetch accepted with `fetch_ack` is held in the next cycle: `instr_valid` is 1, `instr` is the returned data, and `cur_addr` is the fetch address. `fetch_req` and `instr_valid` are never both 1.
- R3: The width of a fetch issued by `advance` comes from status bit 5 (0 = 32-bit, 1 = 16-bit). The next fetch address is the previous one plus 4 for a 32-bit fetch and plus 2 for a 16-bit fetch.
- R4: `pc_visible` equals `cur_addr` plus 8 for a 32-bit instruction and plus 4 for a 16-bit one.
- R5: For a 32-bit instruction, `exec_ok` follows the condition field in bits 31:28, with the flags N, Z, C, V taken from status bits 31, 30, 29, 28. The codes 0 through 14 mean, in order: Z, !Z, C, !C, N, !N, V, !V, C&!Z, Z|!C, N==V, N!=V, !Z&(N==V), Z|(N!=V), and always. Code 15 executes only when instruction bits 27:25 are 101.
- R6: For a 16-bit instruction, `exec_ok` is 1 whatever the flags are.
- R7: `fetch_wait` is entry k of the 32-bit table or of the 16-bit table, selected by the fetch width, where k is `fetch_addr[27:24]`. By default, entry k is k in the 32-bit table and 15-k in the 16-bit table.
- R8: While status bit 7 (interrupt disable) is 1, `irq_req` and `abt_req` have no effect: the held instruction stays and no mode switch occurs.
- R9: On entry, `mode_switch` pulses for one cycle. In that same cycle, `saved_status` holds the old status word, `link_addr` holds `cur_addr`+4, and `new_status` holds the old word with bit 5 cleared, bit 7 set and bits 4:0 set to the entry mode (0x12 for an interrupt, 0x17 for an abort).
- R10: On entry, the block immediately requests a 32-bit fetch at the vector. The vector base is 0xFFFF0000 when `hi_vec` is 1 and 0 otherwise. The offset is 0x18 for an interrupt and 0x0C for an abort.
- R11: When `irq_req` and `abt_req` are both 1 in the same cycle, the abort is taken.
- R12: `halt_req` on a held instruction sets `sleeping`. While sleeping, `advance` has no effect. Exception entry clears `sleeping`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hi_vec | input | 1 | Vector base strap: 1 = 0xFFFF0000, 0 = 0 |
| status_in | input | 32 | Current status word (flags, I, T, mode) |
| fetch_req | output | 1 | Fetch request |
| fetch_addr | output | 32 | Fetch address |
| fetch_wide | output | 1 | 1 = 32-bit fetch, 0 = 16-bit fetch |
| fetch_wait | output | 4 | Wait-cycle hint for this fetch |
| fetch_ack | input | 1 | Fetch data returned this cycle |
| fetch_data | input | 32 | Returned instruction |
| instr_valid | output | 1 | An instruction is held |
| instr | output | 32 | Held instruction |
| cur_addr | output | 32 | Address of held instruction |
| pc_visible | output | 32 | Software-visible program counter |
| exec_ok | output | 1 | Held instruction passes its condition |
| advance | input | 1 | Retire held instruction, fetch next |
| halt_req | input | 1 | Enter wait-for-interrupt |
| sleeping | output | 1 | Waiting for an exception |
| irq_req | input | 1 | Interrupt request |
| abt_req | input | 1 | Prefetch-abort request |
| mode_switch | output | 1 | One-cycle request to the register file to switch mode |
| entry_mode | output | 5 | Mode being entered |
| link_addr | output | 32 | Return address for the link register |
| saved_status | output | 32 | Status word before entry |
| new_status | output | 32 | Status word after entry |

## Verification
A wrong next-fetch register shows up at the very next fetch request: the address or width on the fetch port is wrong, and `cur_addr` and `pc_visible` carry the error one cycle after the acknowledge. A wrong condition decode appears combinationally on `exec_ok` as soon as the flags change, so the bench sweeps every code against all sixteen flag patterns. Errors in the entry path surface in the single cycle that `mode_switch` is high, through the link, status and vector values. Errors in the sleeping flag show up as an `advance` that does or does not start a fetch.

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter logic [31:0] RESET_ADDR = 32'h0,
  parameter logic [31:0] HI_BASE    = 32'hFFFF_0000,
  parameter int          WAIT_W     = 4,
  parameter logic [16*WAIT_W-1:0] WAIT32_TBL = 64'hFEDC_BA98_7654_3210,
  parameter logic [16*WAIT_W-1:0] WAIT16_TBL = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_vec,
  input  logic [31:0]       status_in,
  output logic              fetch_req,
  output logic [31:0]       fetch_addr,
  output logic              fetch_wide,
  output logic [WAIT_W-1:0] fetch_wait,
  input  logic              fetch_ack,
  input  logic [31:0]       fetch_data,
  output logic              instr_valid,
  output logic [31:0]       instr,
  output logic [31:0]       cur_addr,
  output logic [31:0]       pc_visible,
  output logic              exec_ok,
  input  logic              advance,
  input  logic              halt_req,
  output logic              sleeping,
  input  logic              irq_req,
  input  logic              abt_req,
  output logic              mode_switch,
  output logic [4:0]        entry_mode,
  output logic [31:0]       link_addr,
  output logic [31:0]       saved_status,
  output logic [31:0]       new_status
);
  localparam logic [4:0]  MODE_IRQ = 5'h12;
  localparam logic [4:0]  MODE_ABT = 5'h17;
  localparam logic [31:0] OFS_IRQ  = 32'h18;
  localparam logic [31:0] OFS_ABT  = 32'h0C;
  localparam int          T_BIT    = 5;
  localparam int          I_BIT    = 7;

  logic        hold_q, wide_q, cur_wide_q;
  logic [31:0] next_q;

  wire flag_n = status_in[31];
  wire flag_z = status_in[30];
  wire flag_c = status_in[29];
  wire flag_v = status_in[28];
  wire masked = status_in[I_BIT];
  wire take_exc = hold_q && !masked && (irq_req || abt_req);
  wire take_abt = abt_req;
  wire [31:0] base = hi_vec ? HI_BASE : 32'h0;
  wire [3:0] widx = next_q[27:24];

  assign fetch_req   = !hold_q;
  assign fetch_addr  = next_q;
  assign fetch_wide  = wide_q;
  assign fetch_wait  = wide_q ? WAIT32_TBL[widx*WAIT_W +: WAIT_W]
                              : WAIT16_TBL[widx*WAIT_W +: WAIT_W];
  assign instr_valid = hold_q;
  assign pc_visible  = cur_addr + (cur_wide_q ? 32'd8 : 32'd4);

  logic cond_pass;
  always_comb begin
    case (instr[31:28])
      4'h0: cond_pass = flag_z;
      4'h1: cond_pass = !flag_z;
      4'h2: cond_pass = flag_c;
      4'h3: cond_pass = !flag_c;
      4'h4: cond_pass = flag_n;
      4'h5: cond_pass = !flag_n;
      4'h6: cond_pass = flag_v;
      4'h7: cond_pass = !flag_v;
      4'h8: cond_pass = flag_c && !flag_z;
      4'h9: cond_pass = flag_z || !flag_c;
      4'hA: cond_pass = flag_n == flag_v;
      4'hB: cond_pass = flag_n != flag_v;
      4'hC: cond_pass = !flag_z && (flag_n == flag_v);
      4'hD: cond_pass = flag_z || (flag_n != flag_v);
      4'hE: cond_pass = 1'b1;
      default: cond_pass = instr[27:25] == 3'b101;
    endcase
  end
  assign exec_ok = cur_wide_q ? cond_pass : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q       <= 1'b0;
      wide_q       <= 1'b1;
      cur_wide_q   <= 1'b1;
      next_q       <= RESET_ADDR;
      instr        <= '0;
      cur_addr     <= '0;
      sleeping     <= 1'b0;
      mode_switch  <= 1'b0;
      entry_mode   <= '0;
      link_addr    <= '0;
      saved_status <= '0;
      new_status   <= '0;
    end else begin
      mode_switch <= 1'b0;
      if (!hold_q) begin
        if (fetch_ack) begin
          hold_q     <= 1'b1;
          instr      <= fetch_data;
          cur_addr   <= next_q;
          cur_wide_q <= wide_q;
          next_q     <= next_q + (wide_q ? 32'd4 : 32'd2);
        end
      end else if (take_exc) begin
        hold_q       <= 1'b0;
        wide_q       <= 1'b1;
        sleeping     <= 1'b0;
        mode_switch  <= 1'b1;
        entry_mode   <= take_abt ? MODE_ABT : MODE_IRQ;
        next_q       <= base + (take_abt ? OFS_ABT : OFS_IRQ);
        link_addr    <= cur_addr + 32'd4;
        saved_status <= status_in;
        new_status   <= {status_in[31:I_BIT+1], 1'b1, status_in[I_BIT-1:T_BIT+1],
                         1'b0, take_abt ? MODE_ABT : MODE_IRQ};
      end else if (!sleeping) begin
        if (halt_req) begin
          sleeping <= 1'b1;
        end else if (advance) begin
          hold_q <= 1'b0;
          wide_q <= !status_in[T_BIT];
        end
      end
    end
  end
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hi_vec,
  input logic [31:0] status_in,
  input logic        fetch_req,
  input logic [31:0] fetch_addr,
  input logic        fetch_wide,
  input logic        fetch_ack,
  input logic        instr_valid,
  input logic [31:0] cur_addr,
  input logic        irq_req,
  input logic        abt_req,
  input logic        mode_switch,
  input logic [4:0]  entry_mode,
  input logic [31:0] new_status
);
  // R2
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && fetch_ack |=> instr_valid && cur_addr == $past(fetch_addr));
  // R2
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_req, instr_valid}));
  // R8
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && status_in[7] |=> !mode_switch);
  // R9
  entry_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_switch |-> !new_status[5] && new_status[7] && new_status[4:0] == entry_mode);
  // R10
  vector_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_switch |-> fetch_req && fetch_wide &&
      fetch_addr == ((hi_vec ? 32'hFFFF_0000 : 32'h0) +
                     (entry_mode == 5'h17 ? 32'h0C : 32'h18)));
  // R11
  abort_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && !status_in[7] && irq_req && abt_req |=> mode_switch && entry_mode == 5'h17);
  // R9
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_switch |=> !mode_switch);
endmodule

bind fetch_seq fetch_seq_chk chk (
  .clk(clk), .rst_n(rst_n), .hi_vec(hi_vec), .status_in(status_in),
  .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_wide(fetch_wide),
  .fetch_ack(fetch_ack), .instr_valid(instr_valid), .cur_addr(cur_addr),
  .irq_req(irq_req), .abt_req(abt_req), .mode_switch(mode_switch),
  .entry_mode(entry_mode), .new_status(new_status)
);

// File: tb/fetch_seq_test.sv
module fetch_seq_test;
  localparam logic [31:0] RST = 32'h0A00_0000;

  logic clk = 0, rst_n = 0, hi_vec = 0;
  logic [31:0] status_in = 32'h1F;
  logic fetch_ack = 0, advance = 0, halt_req = 0, irq_req = 0, abt_req = 0;
  logic [31:0] fetch_data = 0;
  logic fetch_req, fetch_wide, instr_valid, exec_ok, sleeping, mode_switch;
  logic [3:0] fetch_wait;
  logic [4:0] entry_mode;
  logic [31:0] fetch_addr, instr, cur_addr, pc_visible, link_addr, saved_status, new_status;

  int total = 0, fails = 0;

  fetch_seq #(.RESET_ADDR(RST)) uut (
    .clk(clk), .rst_n(rst_n), .hi_vec(hi_vec), .status_in(status_in),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_wide(fetch_wide),
    .fetch_wait(fetch_wait), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
    .instr_valid(instr_valid), .instr(instr), .cur_addr(cur_addr),
    .pc_visible(pc_visible), .exec_ok(exec_ok), .advance(advance),
    .halt_req(halt_req), .sleeping(sleeping), .irq_req(irq_req), .abt_req(abt_req),
    .mode_switch(mode_switch), .entry_mode(entry_mode), .link_addr(link_addr),
    .saved_status(saved_status), .new_status(new_status));

  always #2 clk = ~clk;

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] d);
    fetch_ack = 1; fetch_data = d;
    tick;
    fetch_ack = 0;
  endtask

  task automatic do_advance;
    advance = 1;
    tick;
    advance = 0;
  endtask

  function automatic logic cond_model(input logic [3:0] c, input logic [3:0] f, input logic [2:0] op);
    logic n, z, cy, v, r;
    {n, z, cy, v} = f;
    case (c[3:1])
      3'd0: r = z;
      3'd1: r = cy;
      3'd2: r = n;
      3'd3: r = v;
      3'd4: r = cy & ~z;
      3'd5: r = n ^ ~v;
      3'd6: r = ~z & (n ^ ~v);
      default: r = 1'b1;
    endcase
    if (c == 4'hF) return op == 3'b101;
    if (c == 4'hE) return 1'b1;
    return c[0] ? ~r : r;
  endfunction

  task automatic t_reset;
    rst_n = 0; tick; tick;
    // R1
    chk("R1 req in reset", fetch_req, 1);
    rst_n = 1; tick;
    chk("R1 addr", fetch_addr, RST);
    chk("R1 wide", fetch_wide, 1);
    chk("R1 no instr", instr_valid, 0);
    chk("R1 no switch", mode_switch, 0);
    // R7 index 0xA, wide
    chk("R7 wait32", fetch_wait, 10);
  endtask

  task automatic t_wide_seq;
    status_in = 32'h1F;
    do_fetch(32'hE000_0001);
    chk("R2 valid", instr_valid, 1);
    chk("R2 instr", instr, 32'hE000_0001);
    chk("R2 cur", cur_addr, RST);
    chk("R2 no req", fetch_req, 0);
    chk("R4 pc wide", pc_visible, RST + 8);
    do_advance;
    chk("R3 next wide addr", fetch_addr, RST + 4);
    chk("R3 wide", fetch_wide, 1);
    do_fetch(32'hE000_0002);
    chk("R4 pc wide 2", pc_visible, RST + 12);
  endtask

  task automatic t_narrow_seq;
    status_in = 32'h3F;
    do_advance;
    chk("R3 narrow addr", fetch_addr, RST + 8);
    chk("R3 narrow", fetch_wide, 0);
    chk("R7 wait16", fetch_wait, 5);
    do_fetch(32'h0000_0000);
    chk("R4 pc narrow", pc_visible, RST + 12);
    status_in = 32'h3F;
    #1 chk("R6 exec narrow Z=0 EQ", exec_ok, 1);
    do_advance;
    chk("R3 narrow step 2", fetch_addr, RST + 10);
    do_fetch(32'h0);
    chk("R4 pc narrow 2", cur_addr + 4, pc_visible);
    chk("R2 cur narrow", cur_addr, RST + 10);
  endtask

  task automatic t_cond;
    status_in = 32'h1F;
    do_advance;
    chk("R3 back to wide", fetch_wide, 1);
    for (int c = 0; c < 17; c++) begin
      logic [3:0] cc = (c == 16) ? 4'hF : c[3:0];
      logic [2:0] op = (c == 16) ? 3'b101 : 3'b000;
      if (!fetch_req) do_advance;
      do_fetch({cc, op, 25'h0});
      for (int f = 0; f < 16; f++) begin
        status_in = {f[3:0], 28'h1F};
        #1 chk("R5 condition", exec_ok, cond_model(cc, f[3:0], op));
      end
      status_in = 32'h1F;
    end
  endtask

  task automatic t_masked;
    logic [31:0] c0;
    c0 = cur_addr;
    status_in = 32'h9F;
    irq_req = 1; abt_req = 1;
    tick; tick;
    irq_req = 0; abt_req = 0;
    chk("R8 no switch", mode_switch, 0);
    chk("R8 still held", instr_valid, 1);
    chk("R8 cur unchanged", cur_addr, c0);
  endtask

  task automatic t_entry(input logic hv, input logic irq, input logic abt);
    logic [31:0] c0, st, vec;
    logic [4:0] m;
    hi_vec = hv;
    c0 = cur_addr;
    st = 32'hA000_003F;
    status_in = st;
    m = abt ? 5'h17 : 5'h12;
    vec = (hv ? 32'hFFFF_0000 : 32'h0) + (abt ? 32'h0C : 32'h18);
    irq_req = irq; abt_req = abt;
    tick;
    irq_req = 0; abt_req = 0;
    // R9
    chk("R9 switch", mode_switch, 1);
    chk("R9 mode", entry_mode, m);
    chk("R9 link", link_addr, c0 + 4);
    chk("R9 saved", saved_status, st);
    chk("R9 new", new_status, {st[31:8], 1'b1, st[6], 1'b0, m});
    // R10, R11
    chk(abt && irq ? "R11 abort vector" : "R10 vector", fetch_addr, vec);
    chk("R10 wide", fetch_wide, 1);
    chk("R12 woken", sleeping, 0);
    chk("R7 wait at vector", fetch_wait, hv ? 15 : 0);
    status_in = 32'h1F;
    tick;
    chk("R9 pulse", mode_switch, 0);
    do_fetch(32'hE000_0000);
    chk("R4 pc at vector", pc_visible, vec + 8);
  endtask

  task automatic t_halt;
    logic [31:0] c0;
    c0 = cur_addr;
    status_in = 32'h1F;
    halt_req = 1; tick; halt_req = 0;
    chk("R12 sleeping", sleeping, 1);
    do_advance;
    tick;
    chk("R12 advance ignored", fetch_req, 0);
    chk("R12 held", cur_addr, c0);
    t_entry(0, 1, 0);
  endtask

  initial begin
    #400000;
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset;
    t_wide_seq;
    t_narrow_seq;
    t_cond;
    t_masked;
    t_entry(0, 1, 0);
    t_entry(1, 0, 1);
    t_entry(1, 1, 1);
    t_masked;
    t_halt;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule